// File: doc/BRIEF.md
# Ethernet Receive Destination Address Filter

This block sits on the receive byte stream of an Ethernet MAC and decides, from the six-byte destination address that opens every frame, whether the frame is kept. A frame is kept in any of these cases: promiscuous operation is selected, the address equals the programmed station address, the address is the all-ones broadcast, or a multicast hash lookup hits. In every other case, and whenever reception is switched off, the frame is refused. The decision and a reason code appear one clock after the sixth address byte is sampled. They stay unchanged until the next frame begins.

The hash lookup runs a reflected CRC-32 over the destination bytes as they arrive, one byte per clock. The top six bits of the running remainder index a 64-bit table held as four 16-bit words. The block also forwards the frame bytes one clock late. When a kept frame is shorter than the minimum length, it appends zero bytes so that the forwarded frame reaches the minimum length. The source must leave the input idle until the padding has been sent.

Top module: `rxaddr_filter`

## Requirements
- R1: With `cfg_rx_en` low at the sixth address byte, the frame is refused: `dec_accept`=0 and `dec_reason`=0 (refuse code).
- R2: With `cfg_rx_en` high and `cfg_promisc` high, the frame is accepted with `dec_reason`=4, whatever the address is.
- R3: Without promiscuous mode, a destination equal to {`sta_w0`,`sta_w1`,`sta_w2`} is accepted with `dec_reason`=1. The first received byte is compared with `sta_w0[15:8]`, the second with `sta_w0[7:0]`, and so on through `sta_w2[7:0]`.
- R4: A destination of six 0xFF bytes that does not match the station address is accepted with `dec_reason`=2. A station match takes precedence, so a broadcast that is also the station address reports 1.
- R5: If the station address and broadcast both miss and `cfg_hash_en` is high, the hash index is bits 31:26 of a CRC over the six bytes in arrival order. The CRC is least significant bit first, uses polynomial 0xEDB88320, starts from 0xFFFFFFFF and is not inverted at the end. Index bits 5:4 (value g) select table word 3-g, where `hash_tbl[16k+15:16k]` is word k. Index bits 3:0 select a bit within that word. A 1 accepts the frame with `dec_reason`=3; a 0 refuses it with code 0.
- R6: If no address rule matches and `cfg_hash_en` is low, the frame is refused with `dec_reason`=0.
- R7: `dec_valid` rises on the clock edge that samples the sixth address byte, so it is visible one cycle after that byte is presented. It then holds with `dec_accept`/`dec_reason` unchanged until the edge that samples the next `in_start`, which clears all three. A frame shorter than six bytes gets no decision.
- R8: Each sampled input byte appears on `out_data` with `out_valid` high one clock later, unchanged. For frames that are not padded, `out_last` marks the last byte.
- R9: An accepted frame of length L, with 6 <= L < 60, is followed directly by 60-L zero bytes, and `out_last` marks the 60th byte. Refused frames, frames of 60 bytes or more, and frames shorter than six bytes are not padded.
- R10: After reset, `dec_valid`, `dec_accept`, `dec_reason` and `out_valid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte strobe |
| in_start | input | 1 | Marks the first byte of a frame (with in_valid) |
| in_last | input | 1 | Marks the final byte of a frame (with in_valid) |
| in_data | input | 8 | Frame byte |
| cfg_rx_en | input | 1 | Reception enable |
| cfg_promisc | input | 1 | Accept every frame |
| cfg_hash_en | input | 1 | Enable multicast hash lookup |
| sta_w0 | input | 16 | Station address bytes 0 (high) and 1 (low) |
| sta_w1 | input | 16 | Station address bytes 2 and 3 |
| sta_w2 | input | 16 | Station address bytes 4 and 5 |
| hash_tbl | input | HASH_WORDS*WORD_W | Hash table; word k at bits 16k+15:16k |
| dec_valid | output | 1 | Decision present for the current frame |
| dec_accept | output | 1 | Frame accepted |
| dec_reason | output | 3 | 0 refuse, 1 station, 2 broadcast, 3 hash, 4 promiscuous |
| out_valid | output | 1 | Forwarded byte strobe |
| out_data | output | 8 | Forwarded or pad byte |
| out_last | output | 1 | Final forwarded byte of the frame |

## Verification
The decision register loads on the edge that samples the sixth byte, so the bench reads `dec_valid` low at the falling edge where that byte is driven and high at the following falling edge. It reads it low again one falling edge after the next start byte. Forwarded bytes lag the input by one edge and pad bytes follow the last byte without a gap. The bench therefore records every output byte at each falling edge from the first driven byte onward, and compares the collected frame length and contents only after an idle window longer than any padding run. Decision values are checked once the frame has ended, which also exercises the hold behaviour.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  localparam int ADDR_BYTES = 6;

  typedef enum logic [2:0] {
    RSN_REJECT  = 3'd0,
    RSN_LOCAL   = 3'd1,
    RSN_BCAST   = 3'd2,
    RSN_HASH    = 3'd3,
    RSN_PROMISC = 3'd4
  } rsn_e;

  // One byte of a reflected CRC, least significant bit first.
  function automatic logic [31:0] crc_byte(input logic [31:0] seed,
                                           input logic [7:0]  din,
                                           input logic [31:0] poly);
    logic [31:0] c;
    c = seed ^ {24'h0, din};
    for (int k = 0; k < 8; k++) begin
      c = c[0] ? ((c >> 1) ^ poly) : (c >> 1);
    end
    return c;
  endfunction

endpackage

// File: rtl/rxf_crc.sv
module rxf_crc #(
  parameter logic [31:0] POLY  = 32'hEDB88320,
  parameter int          IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             restart,
  input  logic [7:0]       din,
  output logic [IDX_W-1:0] hash_idx
);
  import rxf_pkg::*;

  logic [31:0] crc_q, crc_d, seed;

  always_comb begin
    seed     = restart ? 32'hFFFF_FFFF : crc_q;
    crc_d    = crc_byte(seed, din, POLY);
    hash_idx = crc_d[31 -: IDX_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  crc_q <= 32'hFFFF_FFFF;
    else if (en) crc_q <= crc_d;
  end
endmodule

// File: rtl/rxf_match.sv
module rxf_match #(
  parameter int HASH_WORDS = 4,
  parameter int WORD_W     = 16,
  localparam int GW        = $clog2(HASH_WORDS),
  localparam int BW        = $clog2(WORD_W),
  localparam int IDX_W     = GW + BW
) (
  input  logic                         rx_en,
  input  logic                         promisc,
  input  logic                         hash_en,
  input  logic [47:0]                  dst,
  input  logic [47:0]                  station,
  input  logic [HASH_WORDS*WORD_W-1:0] hash_tbl,
  input  logic [IDX_W-1:0]             hash_idx,
  output logic                         accept,
  output rxf_pkg::rsn_e                reason
);
  import rxf_pkg::*;

  logic [GW-1:0]    grp, wsel;
  logic [IDX_W-1:0] bit_pos;
  logic             hash_hit, is_local, is_bcast;

  always_comb begin
    grp      = hash_idx[IDX_W-1 -: GW];
    wsel     = GW'(HASH_WORDS - 1) - grp;     // descending word order
    bit_pos  = {wsel, hash_idx[BW-1:0]};
    hash_hit = hash_tbl[bit_pos];
    is_local = (dst == station);
    is_bcast = (dst == 48'hFFFF_FFFF_FFFF);

    accept = 1'b0;
    reason = RSN_REJECT;
    if (!rx_en) begin
      accept = 1'b0;
      reason = RSN_REJECT;
    end else if (promisc) begin
      accept = 1'b1;
      reason = RSN_PROMISC;
    end else if (is_local) begin
      accept = 1'b1;
      reason = RSN_LOCAL;
    end else if (is_bcast) begin
      accept = 1'b1;
      reason = RSN_BCAST;
    end else if (hash_en && hash_hit) begin
      accept = 1'b1;
      reason = RSN_HASH;
    end
  end
endmodule

// File: rtl/rxf_pad.sv
module rxf_pad #(
  parameter int  MIN_LEN = 60,
  localparam int CW      = $clog2(MIN_LEN + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic       in_start,
  input  logic       in_last,
  input  logic [7:0] in_data,
  input  logic       accept_eff,
  output logic       out_valid,
  output logic [7:0] out_data,
  output logic       out_last
);
  logic [CW-1:0] cnt_q, cnt_d, lenpos, lennext;
  logic          pad_q, pad_d, need;
  logic          ov_d, ol_d;
  logic [7:0]    od_d;

  always_comb begin
    lenpos  = in_start ? '0 : cnt_q;
    lennext = (lenpos < CW'(MIN_LEN)) ? lenpos + 1'b1 : lenpos;
    need    = 1'b0;
    cnt_d   = cnt_q;
    pad_d   = pad_q;
    ov_d    = 1'b0;
    od_d    = in_data;
    ol_d    = 1'b0;
    if (pad_q) begin
      ov_d  = 1'b1;
      od_d  = 8'h00;
      cnt_d = cnt_q + 1'b1;
      ol_d  = (cnt_q == CW'(MIN_LEN - 1));
      pad_d = !ol_d;
    end else if (in_valid) begin
      need  = accept_eff && in_last && (lennext < CW'(MIN_LEN));
      ov_d  = 1'b1;
      cnt_d = lennext;
      ol_d  = in_last && !need;
      pad_d = need;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      pad_q     <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= 8'h00;
      out_last  <= 1'b0;
    end else begin
      cnt_q     <= cnt_d;
      pad_q     <= pad_d;
      out_valid <= ov_d;
      out_data  <= od_d;
      out_last  <= ol_d;
    end
  end

  // R8: a sampled byte is forwarded unchanged on the next cycle
  a_r8_forward: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !pad_q) |=> (out_valid && out_data == $past(in_data)));

  // R9: every padding cycle emits a zero byte
  a_r9_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
    pad_q |=> (out_valid && out_data == 8'h00));
endmodule

// File: rtl/rxaddr_filter.sv
module rxaddr_filter #(
  parameter int          MIN_LEN    = 60,
  parameter int          HASH_WORDS = 4,
  parameter int          WORD_W     = 16,
  parameter logic [31:0] POLY       = 32'hEDB88320
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         in_valid,
  input  logic                         in_start,
  input  logic                         in_last,
  input  logic [7:0]                   in_data,
  input  logic                         cfg_rx_en,
  input  logic                         cfg_promisc,
  input  logic                         cfg_hash_en,
  input  logic [15:0]                  sta_w0,
  input  logic [15:0]                  sta_w1,
  input  logic [15:0]                  sta_w2,
  input  logic [HASH_WORDS*WORD_W-1:0] hash_tbl,
  output logic                         dec_valid,
  output logic                         dec_accept,
  output logic [2:0]                   dec_reason,
  output logic                         out_valid,
  output logic [7:0]                   out_data,
  output logic                         out_last
);
  import rxf_pkg::*;

  localparam int         IDX_W    = $clog2(HASH_WORDS) + $clog2(WORD_W);
  localparam logic [2:0] LAST_POS = 3'(ADDR_BYTES - 1);
  localparam logic [2:0] DONE_POS = 3'(ADDR_BYTES);

  logic [2:0]       pos_q, pos_d, pos;
  logic [39:0]      dst_q, dst_d;
  logic             addr_byte, final_byte, accept_eff;
  logic [IDX_W-1:0] hash_idx;
  logic             m_accept;
  rsn_e             m_reason;
  logic             dv_q, dv_d, da_q, da_d;
  rsn_e             dr_q, dr_d;

  always_comb begin
    pos        = in_start ? 3'd0 : pos_q;
    addr_byte  = in_valid && (pos < DONE_POS);
    final_byte = in_valid && (pos == LAST_POS);
    pos_d      = addr_byte ? pos + 3'd1 : pos_q;
    dst_d      = (addr_byte && !final_byte) ? {dst_q[31:0], in_data} : dst_q;
    accept_eff = final_byte ? m_accept : ((pos == DONE_POS) && da_q);

    dv_d = dv_q;
    da_d = da_q;
    dr_d = dr_q;
    if (final_byte) begin
      dv_d = 1'b1;
      da_d = m_accept;
      dr_d = m_reason;
    end else if (in_valid && in_start) begin
      dv_d = 1'b0;
      da_d = 1'b0;
      dr_d = RSN_REJECT;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= DONE_POS;
      dst_q <= '0;
      dv_q  <= 1'b0;
      da_q  <= 1'b0;
      dr_q  <= RSN_REJECT;
    end else begin
      pos_q <= pos_d;
      dst_q <= dst_d;
      dv_q  <= dv_d;
      da_q  <= da_d;
      dr_q  <= dr_d;
    end
  end

  rxf_crc #(.POLY(POLY), .IDX_W(IDX_W)) u_crc (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (addr_byte),
    .restart  (in_start),
    .din      (in_data),
    .hash_idx (hash_idx)
  );

  rxf_match #(.HASH_WORDS(HASH_WORDS), .WORD_W(WORD_W)) u_match (
    .rx_en    (cfg_rx_en),
    .promisc  (cfg_promisc),
    .hash_en  (cfg_hash_en),
    .dst      ({dst_q, in_data}),
    .station  ({sta_w0, sta_w1, sta_w2}),
    .hash_tbl (hash_tbl),
    .hash_idx (hash_idx),
    .accept   (m_accept),
    .reason   (m_reason)
  );

  rxf_pad #(.MIN_LEN(MIN_LEN)) u_pad (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_start   (in_start),
    .in_last    (in_last),
    .in_data    (in_data),
    .accept_eff (accept_eff),
    .out_valid  (out_valid),
    .out_data   (out_data),
    .out_last   (out_last)
  );

  assign dec_valid  = dv_q;
  assign dec_accept = da_q;
  assign dec_reason = dr_q;

  // R1: reception disabled refuses the frame
  a_r1_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (final_byte && !cfg_rx_en) |=> (dec_valid && !dec_accept && dec_reason == 3'd0));

  // R2: promiscuous mode accepts with its own code
  a_r2_promisc: assert property (@(posedge clk) disable iff (!rst_n)
    (final_byte && cfg_rx_en && cfg_promisc) |=> (dec_valid && dec_accept && dec_reason == 3'd4));

  // R7: decision holds until the next frame start
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !(in_valid && in_start)) |=>
      (dec_valid && $stable(dec_accept) && $stable(dec_reason)));

  // R7: a frame start clears the decision
  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_start) |=> !dec_valid);
endmodule

// File: tb/sim_rxaddr_filter.sv
module sim_rxaddr_filter;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_start, in_last;
  logic [7:0]  in_data;
  logic        cfg_rx_en, cfg_promisc, cfg_hash_en;
  logic [15:0] sta_w0, sta_w1, sta_w2;
  logic [63:0] hash_tbl;
  logic        dec_valid, dec_accept, out_valid, out_last;
  logic [2:0]  dec_reason;
  logic [7:0]  out_data;

  int n_chk = 0;
  int n_err = 0;
  logic [7:0] obuf [0:127];
  logic [7:0] sbuf [0:127];
  int ocnt, olen;

  always #4 clk = ~clk;

  rxaddr_filter u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_start(in_start),
    .in_last(in_last), .in_data(in_data), .cfg_rx_en(cfg_rx_en),
    .cfg_promisc(cfg_promisc), .cfg_hash_en(cfg_hash_en),
    .sta_w0(sta_w0), .sta_w1(sta_w1), .sta_w2(sta_w2), .hash_tbl(hash_tbl),
    .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_reason(dec_reason),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last)
  );

  // stimulus: {rx_en, promisc, hash_en, dst[47:0], len[7:0]}
  localparam logic [58:0] VEC [12] = '{
    {3'b100, 48'h0211_2233_4455, 8'd64},
    {3'b100, 48'h0211_2233_4455, 8'd20},
    {3'b000, 48'h0211_2233_4455, 8'd20},
    {3'b100, 48'hFFFF_FFFF_FFFF, 8'd10},
    {3'b100, 48'h0A0B_0C0D_0E0F, 8'd30},
    {3'b110, 48'h0A0B_0C0D_0E0F, 8'd30},
    {3'b101, 48'h0100_5E00_0001, 8'd40},
    {3'b101, 48'h0100_5E7F_0203, 8'd40},
    {3'b100, 48'h0100_5E00_0001, 8'd40},
    {3'b011, 48'hFFFF_FFFF_FFFF, 8'd12},
    {3'b101, 48'h0211_2233_4455, 8'd6},
    {3'b111, 48'h0211_2233_4455, 8'd60}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [5:0] ref_idx(input logic [47:0] d);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int i = 0; i < 6; i++) begin
      c = c ^ {24'h0, d[47-8*i -: 8]};
      for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return c[31:26];
  endfunction

  function automatic logic [3:0] ref_dec(input logic rx, input logic pm,
                                         input logic he, input logic [47:0] d);
    logic [5:0] ix;
    if (!rx) return 4'h0;
    if (pm) return {1'b1, 3'd4};
    if (d == {sta_w0, sta_w1, sta_w2}) return {1'b1, 3'd1};
    if (d == 48'hFFFF_FFFF_FFFF) return {1'b1, 3'd2};
    if (he) begin
      ix = ref_idx(d);
      if (hash_tbl[(3 - int'(ix[5:4])) * 16 + int'(ix[3:0])]) return {1'b1, 3'd3};
    end
    return 4'h0;
  endfunction

  // sample outputs away from the active edge, before driving new inputs
  task automatic tick();
    @(negedge clk);
    if (out_valid) begin
      if (ocnt < 128) obuf[ocnt] = out_data;
      ocnt++;
      if (out_last) olen = ocnt;
    end
  endtask

  task automatic send_frame(input logic rx, input logic pm, input logic he,
                            input logic [47:0] dst, input int len);
    logic [3:0] e;
    string      tag;
    int         exp_len, bad;
    e = ref_dec(rx, pm, he, dst);
    if (!rx) tag = "R1";
    else if (pm) tag = "R2";
    else if (e[2:0] == 3'd1) tag = "R3";
    else if (e[2:0] == 3'd2) tag = "R4";
    else if (he) tag = "R5";
    else tag = "R6";
    cfg_rx_en = rx; cfg_promisc = pm; cfg_hash_en = he;
    ocnt = 0; olen = -1;
    for (int i = 0; i < len; i++) begin
      tick();
      if (i == 1) chk(dec_valid == 1'b0, "R7", "cleared after start", dec_valid, 0);
      if (i == 5) chk(dec_valid == 1'b0, "R7", "not before sixth byte", dec_valid, 0);
      if (i == 6) chk(dec_valid == 1'b1, "R7", "due after sixth byte", dec_valid, 1);
      sbuf[i]  = (i < 6) ? dst[47-8*i -: 8] : (8'(i) ^ 8'h5A);
      in_valid = 1'b1;
      in_start = (i == 0);
      in_last  = (i == len - 1);
      in_data  = sbuf[i];
    end
    tick();
    in_valid = 1'b0; in_start = 1'b0; in_last = 1'b0; in_data = 8'h00;
    if (len == 6) chk(dec_valid == 1'b1, "R7", "due after sixth byte", dec_valid, 1);
    repeat (70) tick();
    if (len >= 6) begin
      chk(dec_valid == 1'b1, "R7", "held after frame", dec_valid, 1);
      chk({dec_accept, dec_reason} == e, tag, "accept/reason",
          {dec_accept, dec_reason}, e);
    end else begin
      chk(dec_valid == 1'b0, "R7", "no decision for short frame", dec_valid, 0);
    end
    exp_len = (len >= 6 && e[3] && len < 60) ? 60 : len;
    chk(olen == exp_len, (exp_len != len) ? "R9" : "R8", "output length", olen, exp_len);
    bad = 0;
    for (int k = 0; k < exp_len && k < 128; k++)
      if (obuf[k] !== ((k < len) ? sbuf[k] : 8'h00)) bad++;
    chk(bad == 0 && ocnt == exp_len, "R8", "output bytes wrong", bad, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err + 1, n_chk + 1);
    $finish;
  end

  initial begin
    logic [5:0] ia;
    rst_n = 1'b0;
    in_valid = 1'b0; in_start = 1'b0; in_last = 1'b0; in_data = 8'h00;
    cfg_rx_en = 1'b0; cfg_promisc = 1'b0; cfg_hash_en = 1'b0;
    sta_w0 = 16'h0211; sta_w1 = 16'h2233; sta_w2 = 16'h4455;
    hash_tbl = '0;
    ia = ref_idx(48'h0100_5E00_0001);
    hash_tbl[(3 - int'(ia[5:4])) * 16 + int'(ia[3:0])] = 1'b1;
    ocnt = 0; olen = -1;
    repeat (3) tick();
    // R10: reset state
    chk({dec_valid, dec_accept, dec_reason, out_valid} == 6'b0, "R10",
        "reset outputs", {dec_valid, dec_accept, dec_reason, out_valid}, 0);
    rst_n = 1'b1;
    repeat (2) tick();
    chk({dec_valid, dec_accept, dec_reason, out_valid} == 6'b0, "R10",
        "outputs after release", {dec_valid, dec_accept, dec_reason, out_valid}, 0);

    for (int v = 0; v < 12; v++)
      send_frame(VEC[v][58], VEC[v][57], VEC[v][56], VEC[v][55:8], int'(VEC[v][7:0]));

    // R9: frame shorter than the address gets neither decision nor padding
    send_frame(1'b1, 1'b0, 1'b0, 48'h0211_2233_4455, 4);

    // R4: station equal to broadcast reports the station code
    sta_w0 = 16'hFFFF; sta_w1 = 16'hFFFF; sta_w2 = 16'hFFFF;
    send_frame(1'b1, 1'b0, 1'b0, 48'hFFFF_FFFF_FFFF, 12);
    chk(dec_reason == 3'd1, "R4", "station precedence", dec_reason, 1);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule